// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block holds received CAN messages until a host processor has dealt with them. A receive engine upstream delivers each message as a stream of bytes, one byte per strobed cycle. The first byte carries a start marker and the last byte carries an end marker. The first byte is a header that gives the frame format and the data length. It is followed by the identifier bytes and then the data bytes. Messages are kept whole in a circular byte store. A message that is incomplete, malformed or too large for the free space is never counted.

The host always sees the oldest complete message through a byte-addressed read window. It frees that message with a one-cycle release pulse, and the next message then becomes visible at offset 0 of the window. Status outputs report the number of complete messages, a not-empty flag, a sticky overrun flag, and a missing-packet flag. The missing-packet flag is raised while the head slot is occupied by a message that is still arriving. Two interrupt requests are gated by separate enable inputs.

Top module: `canrx_msg_fifo`

## Requirements
- R1: `msg_count` equals the number of complete messages held, and `rx_not_empty` is 1 exactly when `msg_count` is non-zero.
- R2: The header byte sets the message length. Bit 7 set means 4 identifier bytes, clear means 2. Bit 6 set means a remote frame with no data bytes. Bits 3:0 give the data byte count, with any value above 8 treated as 8. Length = 1 + identifier bytes + data bytes.
- R3: A message whose end marker arrives after a byte count other than the header-derived length is discarded without setting overrun. Bytes strobed outside a message (no start marker seen) are ignored.
- R4: `host_rd_data` combinationally shows the byte at offset `host_rd_addr` of the oldest complete message. Offset 0 is the header.
- R5: A `cmd_release` pulse while `msg_count` is non-zero frees the oldest message. A pulse while `msg_count` is zero has no effect.
- R6: A message completing in the same cycle as a release is stored, the oldest message is freed, and `msg_count` stays unchanged.
- R7: Free space is DEPTH minus the bytes held by complete messages, measured before any release in the same cycle. A message with more bytes than the free space is dropped entirely and sets `overrun`. The bytes held by complete messages are never disturbed.
- R8: `overrun` stays set until a `cmd_clr_overrun` pulse clears it. If an overrun event and a clear fall in the same cycle, the flag ends up set.
- R9: `missing` is 1 while a message is arriving and no complete message is held. Otherwise it is 0.
- R10: `irq_rx` = `rx_not_empty` AND `irq_rx_en`, and `irq_ovr` = `overrun` AND `irq_ovr_en`.
- R11: After reset, `msg_count` is 0 and `rx_not_empty`, `overrun`, `missing`, `irq_rx` and `irq_ovr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_wr_valid | input | 1 | Byte strobe from the receive engine |
| rx_wr_sof | input | 1 | Marks the header byte of a message |
| rx_wr_eof | input | 1 | Marks the last byte of a message |
| rx_wr_data | input | 8 | Message byte |
| host_rd_addr | input | AW (6) | Byte offset into the oldest message |
| host_rd_data | output | 8 | Byte at that offset |
| cmd_release | input | 1 | One-cycle pulse that frees the oldest message |
| cmd_clr_overrun | input | 1 | One-cycle pulse that clears the overrun flag |
| irq_rx_en | input | 1 | Receive interrupt enable |
| irq_ovr_en | input | 1 | Overrun interrupt enable |
| msg_count | output | CNT_W (7) | Number of complete messages held |
| rx_not_empty | output | 1 | At least one complete message held |
| overrun | output | 1 | Sticky overrun flag |
| missing | output | 1 | Head slot is occupied by a message still arriving |
| irq_rx | output | 1 | Receive interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
A wrong head pointer or wrong length decode shows up at the very next release. The window then starts mid-message, and every byte compare on the following message fails. A byte-occupancy error appears later and less directly. The block reports overrun one message too early or too late, and the sweeps that fill the store to the brim catch this on the first wrap. Errors in the count or in the flags show on the status outputs one cycle after the triggering edge, so the bench compares them after every message and every command.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

   // widest message: header + 4 id bytes + 8 data bytes = 13
   localparam int unsigned LEN_W    = 5;
   localparam int unsigned MAX_DATA = 8;
   localparam int unsigned MIN_LEN  = 3;

   typedef struct packed {
      logic       ext;   // 4 identifier bytes when set, 2 otherwise
      logic       rtr;   // remote frame: no data bytes
      logic [1:0] rsv;
      logic [3:0] dlc;
   } rx_hdr_t;

   function automatic logic [LEN_W-1:0] msg_len(input rx_hdr_t h);
      logic [LEN_W-1:0] id_b;
      logic [LEN_W-1:0] dat_b;
      id_b = h.ext ? LEN_W'(4) : LEN_W'(2);
      if (h.rtr)
         dat_b = '0;
      else if (32'(h.dlc) > MAX_DATA)
         dat_b = LEN_W'(MAX_DATA);
      else
         dat_b = LEN_W'(h.dlc);
      return LEN_W'(1) + id_b + dat_b;
   endfunction

endpackage

// File: rtl/canrx_len_decode.sv
module canrx_len_decode
   import canrx_pkg::*;
(
   input  logic [7:0]       hdr_i,
   output logic [LEN_W-1:0] len_o
);
   rx_hdr_t hdr;

   always_comb begin
      hdr   = rx_hdr_t'(hdr_i);
      len_o = msg_len(hdr);
   end
endmodule

// File: rtl/canrx_byte_store.sv
module canrx_byte_store #(
   parameter  int unsigned DEPTH  = 64,
   parameter  bit          RD_REG = 1'b0,
   localparam int unsigned AW     = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o,
   input  logic [AW-1:0] haddr_i,
   output logic [7:0]    hdata_o
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   // header port for the release path is always combinational
   assign hdata_o = mem[haddr_i];

   generate
      if (RD_REG) begin : g_rd_reg
         logic [7:0] rdata_q;
         always_ff @(posedge clk) rdata_q <= mem[raddr_i];
         assign rdata_o = rdata_q;
      end else begin : g_rd_comb
         assign rdata_o = mem[raddr_i];
      end
   endgenerate
endmodule

// File: rtl/canrx_wr_ctrl.sv
module canrx_wr_ctrl
   import canrx_pkg::*;
#(
   parameter  int unsigned DEPTH = 64,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned UW    = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid_i,
   input  logic             wr_sof_i,
   input  logic             wr_eof_i,
   input  logic [7:0]       wr_data_i,
   input  logic [AW-1:0]    tail_i,
   input  logic [UW-1:0]    free_i,
   input  logic [LEN_W-1:0] exp_len_i,
   output logic [7:0]       hdr_o,
   output logic             mem_we_o,
   output logic [AW-1:0]    mem_waddr_o,
   output logic             commit_o,
   output logic [UW-1:0]    commit_len_o,
   output logic             ovr_evt_o,
   output logic             busy_o
);
   logic          busy_q;
   logic [UW-1:0] pend_q;
   logic [7:0]    hdr_q;

   logic start, cont, room_start, room_cont;

   always_comb begin
      start        = wr_valid_i & wr_sof_i;
      cont         = wr_valid_i & ~wr_sof_i & busy_q;
      room_start   = (free_i != '0);
      room_cont    = (pend_q < free_i);
      mem_we_o     = (start & room_start) | (cont & room_cont);
      mem_waddr_o  = tail_i + (start ? '0 : pend_q[AW-1:0]);
      ovr_evt_o    = (start & ~room_start) | (cont & ~room_cont);
      commit_len_o = pend_q + UW'(1);
      commit_o     = cont & room_cont & wr_eof_i &
                     (commit_len_o == UW'(exp_len_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         hdr_q  <= '0;
      end else if (start) begin
         busy_q <= room_start & ~wr_eof_i;
         pend_q <= UW'(1);
         hdr_q  <= wr_data_i;
      end else if (cont) begin
         busy_q <= room_cont & ~wr_eof_i;
         pend_q <= pend_q + UW'(1);
      end
   end

   assign hdr_o  = hdr_q;
   assign busy_o = busy_q;

   // R3
   busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(wr_valid_i && wr_sof_i));

   // R7
   pend_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (pend_q <= free_i));
endmodule

// File: rtl/canrx_msg_fifo.sv
module canrx_msg_fifo
   import canrx_pkg::*;
#(
   parameter  int unsigned DEPTH  = 64,
   parameter  int unsigned CNT_W  = 7,
   parameter  bit          RD_REG = 1'b0,
   localparam int unsigned AW     = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_wr_valid,
   input  logic             rx_wr_sof,
   input  logic             rx_wr_eof,
   input  logic [7:0]       rx_wr_data,
   input  logic [AW-1:0]    host_rd_addr,
   output logic [7:0]       host_rd_data,
   input  logic             cmd_release,
   input  logic             cmd_clr_overrun,
   input  logic             irq_rx_en,
   input  logic             irq_ovr_en,
   output logic [CNT_W-1:0] msg_count,
   output logic             rx_not_empty,
   output logic             overrun,
   output logic             missing,
   output logic             irq_rx,
   output logic             irq_ovr
);
   localparam int unsigned   UW      = AW + 1;
   localparam logic [UW-1:0] DEPTH_U = UW'(DEPTH);

   generate
      if ((32'(1) << AW) != DEPTH || DEPTH < 16) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 16");
      end
      if ((DEPTH / MIN_LEN) >= (32'(1) << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for the message count DEPTH allows");
      end
   endgenerate

   logic [AW-1:0]    head_q;
   logic [UW-1:0]    used_q;
   logic [CNT_W-1:0] count_q;
   logic             ovr_q;

   logic [AW-1:0]    tail, mem_waddr, rd_abs;
   logic [UW-1:0]    free_sp, commit_len;
   logic [7:0]       hdr_cur, head_hdr;
   logic [LEN_W-1:0] exp_len, head_len;
   logic             mem_we, commit, ovr_evt, busy, rel;

   always_comb begin
      free_sp = DEPTH_U - used_q;
      tail    = head_q + used_q[AW-1:0];
      rd_abs  = head_q + host_rd_addr;
      rel     = cmd_release & (count_q != '0);
   end

   canrx_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_valid_i   (rx_wr_valid),
      .wr_sof_i     (rx_wr_sof),
      .wr_eof_i     (rx_wr_eof),
      .wr_data_i    (rx_wr_data),
      .tail_i       (tail),
      .free_i       (free_sp),
      .exp_len_i    (exp_len),
      .hdr_o        (hdr_cur),
      .mem_we_o     (mem_we),
      .mem_waddr_o  (mem_waddr),
      .commit_o     (commit),
      .commit_len_o (commit_len),
      .ovr_evt_o    (ovr_evt),
      .busy_o       (busy)
   );

   canrx_len_decode u_len_in   (.hdr_i(hdr_cur),  .len_o(exp_len));
   canrx_len_decode u_len_head (.hdr_i(head_hdr), .len_o(head_len));

   canrx_byte_store #(.DEPTH(DEPTH), .RD_REG(RD_REG)) u_store (
      .clk     (clk),
      .we_i    (mem_we),
      .waddr_i (mem_waddr),
      .wdata_i (rx_wr_data),
      .raddr_i (rd_abs),
      .rdata_o (host_rd_data),
      .haddr_i (head_q),
      .hdata_o (head_hdr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         used_q  <= '0;
         count_q <= '0;
         ovr_q   <= 1'b0;
      end else begin
         used_q  <= used_q + (commit ? commit_len : '0)
                           - (rel ? UW'(head_len) : '0);
         count_q <= count_q + CNT_W'(commit) - CNT_W'(rel);
         if (rel) head_q <= head_q + AW'(head_len);
         if (ovr_evt)              ovr_q <= 1'b1;
         else if (cmd_clr_overrun) ovr_q <= 1'b0;
      end
   end

   always_comb begin
      msg_count    = count_q;
      rx_not_empty = (count_q != '0);
      overrun      = ovr_q;
      missing      = busy & (count_q == '0);
      irq_rx       = rx_not_empty & irq_rx_en;
      irq_ovr      = ovr_q & irq_ovr_en;
   end

   // R1
   count_matches_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0) == (used_q == '0));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      used_q <= DEPTH_U);

   // R5
   release_empty_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_release && count_q == '0) |=> $stable(head_q));

   // R6
   push_release_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && cmd_release && count_q != '0) |=> $stable(count_q));

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !cmd_clr_overrun) |=> ovr_q);

   // R8
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clr_overrun && !ovr_evt) |=> !ovr_q);

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_rx && !irq_rx_en) && !(irq_ovr && !irq_ovr_en));
endmodule

// File: tb/canrx_msg_fifo_tb.sv
module canrx_msg_fifo_tb_top;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_wr_valid = 0, rx_wr_sof = 0, rx_wr_eof = 0;
   logic [7:0] rx_wr_data = 0;
   logic [5:0] host_rd_addr = 0;
   logic [7:0] host_rd_data;
   logic       cmd_release = 0, cmd_clr_overrun = 0;
   logic       irq_rx_en = 0, irq_ovr_en = 0;
   logic [6:0] msg_count;
   logic       rx_not_empty, overrun, missing, irq_rx, irq_ovr;

   always #5 clk = ~clk;

   canrx_msg_fifo dut_i (
      .clk(clk), .rst_n(rst_n),
      .rx_wr_valid(rx_wr_valid), .rx_wr_sof(rx_wr_sof), .rx_wr_eof(rx_wr_eof),
      .rx_wr_data(rx_wr_data), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
      .cmd_release(cmd_release), .cmd_clr_overrun(cmd_clr_overrun),
      .irq_rx_en(irq_rx_en), .irq_ovr_en(irq_ovr_en),
      .msg_count(msg_count), .rx_not_empty(rx_not_empty), .overrun(overrun),
      .missing(missing), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
   );

   int nvec = 0;
   int nerr = 0;

   // reference model
   int m_used = 0;
   int m_count = 0;
   bit m_ovr = 0;
   int m_bytes[$];
   int m_lens[$];

   task automatic chk(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int hlen(input logic [7:0] h);
      int d;
      d = h[6] ? 0 : ((h[3:0] > 8) ? 8 : int'(h[3:0]));
      return 1 + (h[7] ? 4 : 2) + d;
   endfunction

   function automatic void model_release();
      if (m_count > 0) begin
         for (int k = 0; k < m_lens[0]; k++) void'(m_bytes.pop_front());
         m_used -= m_lens[0];
         void'(m_lens.pop_front());
         m_count--;
      end
   endfunction

   task automatic check_all(input string req);
      chk({req, " count"}, msg_count, m_count);
      chk({req, " not_empty"}, rx_not_empty, m_count != 0);
      chk({req, " overrun"}, overrun, m_ovr);
      chk({req, " missing"}, missing, 0);
      chk({req, " irq_rx"}, irq_rx, (m_count != 0) && irq_rx_en);
      chk({req, " irq_ovr"}, irq_ovr, m_ovr && irq_ovr_en);
      if (m_count > 0) begin
         for (int k = 0; k < m_lens[0]; k++) begin
            host_rd_addr = 6'(k);
            #1;
            chk({req, " R4 window"}, host_rd_data, m_bytes[k]);
         end
      end
   endtask

   // n: bytes actually streamed; clr_idx: byte on which to pulse clear (-1 none)
   // pause_at: idle one cycle after this byte and check the missing flag (-1 none)
   task automatic push(input logic [7:0] hdr, input int n, input int seed,
                       input bit rel_last, input int clr_idx, input int pause_at);
      int b[16];
      int fr;
      fr = DEPTH - m_used;
      for (int i = 0; i < n; i++) b[i] = (i == 0) ? int'(hdr) : ((seed * 13 + i * 29 + 7) & 255);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_wr_valid = 1; rx_wr_sof = (i == 0); rx_wr_eof = (i == n - 1);
         rx_wr_data = 8'(b[i]);
         cmd_release = rel_last && (i == n - 1);
         cmd_clr_overrun = (i == clr_idx);
         if (i == pause_at) begin
            @(negedge clk);
            rx_wr_valid = 0; rx_wr_sof = 0; rx_wr_eof = 0;
            cmd_release = 0; cmd_clr_overrun = 0;
            // R9: head slot incomplete only when nothing complete is held
            chk("R9 missing", missing, (m_count == 0) && (i < fr));
         end
      end
      @(negedge clk);
      rx_wr_valid = 0; rx_wr_sof = 0; rx_wr_eof = 0;
      cmd_release = 0; cmd_clr_overrun = 0;
      if (n > fr) m_ovr = !(clr_idx > fr);
      else begin
         if (clr_idx >= 0) m_ovr = 0;
         if (n == hlen(hdr)) begin
            for (int i = 0; i < n; i++) m_bytes.push_back(b[i]);
            m_lens.push_back(n);
            m_used += n;
            m_count++;
         end
      end
      if (rel_last) model_release();
   endtask

   task automatic release_cmd();
      @(negedge clk); cmd_release = 1;
      @(negedge clk); cmd_release = 0;
      model_release();
   endtask

   task automatic clr_cmd();
      @(negedge clk); cmd_clr_overrun = 1;
      @(negedge clk); cmd_clr_overrun = 0;
      m_ovr = 0;
   endtask

   task automatic drain(input string req);
      while (m_count > 0) begin
         release_cmd();
         check_all(req);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nvec++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int seed;
      seed = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 count", msg_count, 0);
      chk("R11 not_empty", rx_not_empty, 0);
      chk("R11 overrun", overrun, 0);
      chk("R11 missing", missing, 0);
      chk("R11 irq", {irq_rx, irq_ovr}, 0);

      irq_rx_en = 1; irq_ovr_en = 1;

      // R1 R2 R7: sweep every header form until the store overflows, then drain
      for (int ext = 0; ext < 2; ext++)
         for (int rtr = 0; rtr < 2; rtr++)
            for (int dlc = 0; dlc < 16; dlc++) begin
               logic [7:0] h;
               h = {1'(ext), 1'(rtr), 2'b00, 4'(dlc)};
               push(h, hlen(h), seed++, 0, -1, -1);
               check_all("R2");
               if (m_ovr) begin
                  check_all("R7");
                  drain("R5");
                  clr_cmd();
                  check_all("R8");
               end
            end
      drain("R5");

      // R5: release with nothing held leaves the head in place
      release_cmd();
      check_all("R5");
      push(8'h01, 4, seed++, 0, -1, -1);
      check_all("R5");

      // R3: wrong-length messages and stray bytes
      push(8'h02, 4, seed++, 0, -1, -1);
      check_all("R3");
      push(8'h02, 6, seed++, 0, -1, -1);
      check_all("R3");
      @(negedge clk); rx_wr_valid = 1; rx_wr_data = 8'hA5;
      @(negedge clk); rx_wr_valid = 0;
      check_all("R3");

      // R6: completion and release in the same cycle
      push(8'h83, 8, seed++, 0, -1, -1);
      push(8'h05, 8, seed++, 1, -1, -1);
      check_all("R6");
      push(8'h48, 5, seed++, 1, -1, -1);
      check_all("R6");
      drain("R6");

      // R9: partial message into an empty store, then behind a held one
      push(8'h03, 6, seed++, 0, -1, 2);
      check_all("R9");
      push(8'h01, 4, seed++, 0, -1, 1);
      check_all("R9");
      drain("R9");

      // R8: overrun event coinciding with a clear pulse
      while (DEPTH - m_used >= 13) push(8'h05, 8, seed++, 0, -1, -1);
      push(8'h88, 13, seed++, 0, DEPTH - m_used, -1);
      check_all("R8");

      // R10: enable combinations with both sources active
      for (int e = 0; e < 4; e++) begin
         irq_rx_en = e[0]; irq_ovr_en = e[1];
         #1;
         chk("R10 irq_rx", irq_rx, e[0]);
         chk("R10 irq_ovr", irq_ovr, e[1]);
      end
      irq_rx_en = 1; irq_ovr_en = 1;
      clr_cmd();
      check_all("R8");
      drain("R7");

      summary();
      $finish;
   end
endmodule